// File: doc/BRIEF.md
# I2C Bus Busy Monitor

This block watches the two wires of an I2C bus and keeps a bus-busy flag that a master or slave engine consults before it begins a transfer. Both lines pass through two-flop synchronizers. A falling SDA while SCL is high is a start condition, and it sets the flag. A rising SDA while SCL is high is a stop condition, and it clears the flag. Each condition also gives a one-cycle pulse, and a stop can raise a gated interrupt pulse.

On enable, the flag does not come from the sensed bus. A configuration input sets its first value: either "assume the bus is taken" or "assume the bus is free". A local-release command takes the block out of the current transfer, and the block goes on watching for the next start. A stop request latches a pending bit that software has no way to clear. A small generator then drives a stop onto the bus through open-drain pull-down outputs, and the pending bit drops only when that stop has been completed.

Top module: `i2c_busy_monitor`

## Requirements
- R1: On the first clock with `en` high after it was low, with `assume_idle` = 0, `bus_busy` becomes 1 whatever the bus lines show.
- R2: On that same enabling clock with `assume_idle` = 1, `bus_busy` becomes 0 whatever the bus lines show, even with SDA held low.
- R3: A falling SDA while SCL is high sets `bus_busy` to 1 and gives a `start_det` pulse exactly one cycle wide.
- R4: A rising SDA while SCL is high clears `bus_busy` to 0 and gives a `stop_det` pulse exactly one cycle wide.
- R5: SDA transitions while SCL is low produce no start or stop pulse and leave `bus_busy` unchanged.
- R6: `stop_irq` pulses in the same cycle as `stop_det` only when `stop_irq_en` is 1. With it at 0, a stop still clears `bus_busy` but `stop_irq` stays 0.
- R7: `stop_req` while enabled sets `stop_pending`. The generator then pulls SCL low, then also pulls SDA low, then releases SCL, then (once SCL reads high) releases SDA. The resulting stop clears `bus_busy`. `stop_pending` returns to 0 only when this sequence completes.
- R8: `engaged` goes to 1 on a detected start. A one-cycle `release_cmd` drops it to 0 on the next clock while `bus_busy` stays 1. The next start sets it again.
- R9: With `en` low, `bus_busy`, `start_det`, `stop_det`, `stop_irq`, `engaged`, `sda_pull` and `scl_pull` are all 0 from the next clock. Starts on the bus are ignored.
- R10: A line change reaches the outputs on the third rising clock edge after it, and not on the second (two synchronizer flops plus the output register).
- R11: Dropping `en` during stop generation releases both pulls but keeps `stop_pending` at 1. After re-enabling, the sequence runs again and completes. `stop_req` while disabled is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sda_i | input | 1 | SDA line as seen on the bus (asynchronous) |
| scl_i | input | 1 | SCL line as seen on the bus (asynchronous) |
| en | input | 1 | Block enable |
| assume_idle | input | 1 | Busy value at enable: 0 gives busy, 1 gives free |
| stop_irq_en | input | 1 | Gates `stop_irq` on detected stops |
| release_cmd | input | 1 | Leave the current transfer |
| stop_req | input | 1 | Request generation of a stop condition |
| bus_busy | output | 1 | Bus-busy flag |
| start_det | output | 1 | One-cycle pulse on a detected start |
| stop_det | output | 1 | One-cycle pulse on a detected stop |
| stop_irq | output | 1 | Gated stop interrupt pulse |
| engaged | output | 1 | Block is taking part in the current transfer |
| stop_pending | output | 1 | Stop request not yet completed |
| sda_pull | output | 1 | Pull SDA low (open drain) |
| scl_pull | output | 1 | Pull SCL low (open drain) |

## Verification
The detector is exercised with a start and a stop made while SCL is high, and with SDA toggles made while SCL is low. Together these separate real conditions from data changes, and the cycle-exact sampling pins down the synchronizer latency. The initial busy value is tested with both settings of `assume_idle`, once with SDA held low mid-transfer, so a flag that tracks the bus instead of the option is caught. The stop generator runs on a wired-AND bus model. Its drive order is tracked phase by phase, and an interrupted run shows that the pending bit survives disable.

// File: rtl/i2c_mon_pkg.sv
// Package: shared types for the I2C bus busy monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package i2c_mon_pkg;

    // Phases of the stop-condition generator.
    typedef enum logic [2:0] {
        GEN_IDLE    = 3'd0,
        GEN_SCL_LOW = 3'd1,
        GEN_SDA_LOW = 3'd2,
        GEN_SCL_REL = 3'd3,
        GEN_SDA_REL = 3'd4
    } gen_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Synchronizes a vector of asynchronous bus lines into the clock domain
// through STAGES flops per bit.
// Assumes: lines idle high, so the reset value is all ones by default.
module i2c_line_sync #(
    parameter int          WIDTH     = 2,
    parameter int          STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift one stage of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe[s] <= {WIDTH{RESET_VAL}};
                end else if (s == 0) begin
                    pipe[s] <= async_i;
                end else begin
                    pipe[s] <= pipe[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = pipe[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
// Module: i2c_cond_detect
// Flags start (SDA falls, SCL high) and stop (SDA rises, SCL high) by
// comparing the current synchronized sample with the previous one.
// Assumes: inputs are already synchronized; outputs are combinational.
module i2c_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_s,
    input  logic scl_s,
    output logic start_raw,
    output logic stop_raw
);
    logic sda_p;
    logic scl_p;

    // Keep the previous sample of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_p <= 1'b1;
            scl_p <= 1'b1;
        end else begin
            sda_p <= sda_s;
            scl_p <= scl_s;
        end
    end

    // SCL must be high in both samples so a simultaneous SCL change never counts.
    always_comb begin
        start_raw = scl_s && scl_p &&  sda_p && !sda_s;
        stop_raw  = scl_s && scl_p && !sda_p &&  sda_s;
    end
endmodule

// File: rtl/i2c_stop_gen.sv
// Module: i2c_stop_gen
// Drives a stop condition onto an open-drain bus: pull SCL, pull SDA,
// release SCL, wait for SCL high, release SDA. Holds a pending request
// that only completion of the sequence clears.
// Assumes: PHASE_CYCLES >= 1; scl_s is the synchronized SCL line.
module i2c_stop_gen
    import i2c_mon_pkg::*;
#(
    parameter int PHASE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic req,
    input  logic scl_s,
    output logic pending,
    output logic sda_pull,
    output logic scl_pull
);
    localparam int CW = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(PHASE_CYCLES - 1);

    gen_state_t   state;
    logic [CW-1:0] cnt;
    logic          cnt_done;

    assign cnt_done = (cnt == CNT_LAST);

    // Sequence the stop phases; disabling drops back to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= GEN_IDLE;
            cnt   <= '0;
        end else if (!en) begin
            state <= GEN_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                GEN_IDLE: begin
                    cnt <= '0;
                    if (pending) state <= GEN_SCL_LOW;
                end
                GEN_SCL_LOW, GEN_SDA_LOW, GEN_SDA_REL: begin
                    if (cnt_done) begin
                        cnt <= '0;
                        if (state == GEN_SCL_LOW)      state <= GEN_SDA_LOW;
                        else if (state == GEN_SDA_LOW) state <= GEN_SCL_REL;
                        else                           state <= GEN_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                GEN_SCL_REL: begin
                    if (!cnt_done) begin
                        cnt <= cnt + 1'b1;
                    end else if (scl_s) begin
                        cnt   <= '0;
                        state <= GEN_SDA_REL;
                    end
                end
                default: state <= GEN_IDLE;
            endcase
        end
    end

    // Latch requests while enabled; clear only when the sequence completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (en && state == GEN_SDA_REL && cnt_done) begin
            pending <= 1'b0;
        end else if (en && req) begin
            pending <= 1'b1;
        end
    end

    // Decode open-drain drives from the phase.
    always_comb begin
        scl_pull = (state == GEN_SCL_LOW) || (state == GEN_SDA_LOW);
        sda_pull = (state == GEN_SDA_LOW) || (state == GEN_SCL_REL);
    end
endmodule

// File: rtl/i2c_busy_monitor.sv
// Module: i2c_busy_monitor (top)
// Tracks the I2C bus-busy state from detected start/stop conditions,
// seeds it from a configuration input on enable, emits condition pulses,
// a gated stop interrupt, a participation flag, and generates stops on request.
// Assumes: sda_i/scl_i are the wired bus levels; single clock domain.
module i2c_busy_monitor #(
    parameter int SYNC_STAGES  = 2,
    parameter int PHASE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_i,
    input  logic scl_i,
    input  logic en,
    input  logic assume_idle,
    input  logic stop_irq_en,
    input  logic release_cmd,
    input  logic stop_req,
    output logic bus_busy,
    output logic start_det,
    output logic stop_det,
    output logic stop_irq,
    output logic engaged,
    output logic stop_pending,
    output logic sda_pull,
    output logic scl_pull
);
    localparam int LINES = 2;

    logic [LINES-1:0] lines_s;
    logic             sda_s;
    logic             scl_s;
    logic             start_raw;
    logic             stop_raw;
    logic             en_q;

    i2c_line_sync #(
        .WIDTH     (LINES),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  (lines_s)
    );

    assign sda_s = lines_s[0];
    assign scl_s = lines_s[1];

    i2c_cond_detect u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_s     (scl_s),
        .start_raw (start_raw),
        .stop_raw  (stop_raw)
    );

    i2c_stop_gen #(
        .PHASE_CYCLES (PHASE_CYCLES)
    ) u_stopgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .req      (stop_req),
        .scl_s    (scl_s),
        .pending  (stop_pending),
        .sda_pull (sda_pull),
        .scl_pull (scl_pull)
    );

    // Update busy flag, pulses and participation; seed busy on enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            bus_busy  <= 1'b0;
            start_det <= 1'b0;
            stop_det  <= 1'b0;
            stop_irq  <= 1'b0;
            engaged   <= 1'b0;
        end else if (!en) begin
            en_q      <= 1'b0;
            bus_busy  <= 1'b0;
            start_det <= 1'b0;
            stop_det  <= 1'b0;
            stop_irq  <= 1'b0;
            engaged   <= 1'b0;
        end else if (!en_q) begin
            en_q      <= 1'b1;
            bus_busy  <= !assume_idle;
            start_det <= 1'b0;
            stop_det  <= 1'b0;
            stop_irq  <= 1'b0;
            engaged   <= 1'b0;
        end else begin
            start_det <= start_raw;
            stop_det  <= stop_raw;
            stop_irq  <= stop_raw && stop_irq_en;
            if (start_raw)     bus_busy <= 1'b1;
            else if (stop_raw) bus_busy <= 1'b0;
            if (start_raw)                    engaged <= 1'b1;
            else if (stop_raw || release_cmd) engaged <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_busy_monitor_chk.sv
// Module: i2c_busy_monitor_chk
// Concurrent checks on the monitor's ports, bound into every instance.
// Assumes: synchronous active-low reset.
module i2c_busy_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic assume_idle,
    input logic bus_busy,
    input logic start_det,
    input logic stop_det,
    input logic stop_irq,
    input logic engaged,
    input logic stop_pending,
    input logic sda_pull,
    input logic scl_pull
);
    // R1 R2
    enable_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |=> (bus_busy == !$past(assume_idle)));

    // R3
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |-> bus_busy);

    // R3
    start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !start_det);

    // R4
    stop_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |-> !bus_busy);

    // R6
    irq_follows_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_irq |-> stop_det);

    // R9
    disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!bus_busy && !start_det && !stop_det && !stop_irq
                 && !engaged && !sda_pull && !scl_pull));

    // R11
    pending_clear_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_pending) |-> $past(en));
endmodule

bind i2c_busy_monitor i2c_busy_monitor_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .assume_idle  (assume_idle),
    .bus_busy     (bus_busy),
    .start_det    (start_det),
    .stop_det     (stop_det),
    .stop_irq     (stop_irq),
    .engaged      (engaged),
    .stop_pending (stop_pending),
    .sda_pull     (sda_pull),
    .scl_pull     (scl_pull)
);

// File: tb/tb_i2c_busy_monitor.sv
`timescale 1ns/1ps
module tb_i2c_busy_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sda_tb = 1'b1;
    logic scl_tb = 1'b1;
    logic en = 1'b0;
    logic assume_idle = 1'b0;
    logic stop_irq_en = 1'b0;
    logic release_cmd = 1'b0;
    logic stop_req = 1'b0;
    logic bus_busy, start_det, stop_det, stop_irq, engaged;
    logic stop_pending, sda_pull, scl_pull;
    logic sda_line, scl_line;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    // Wired-AND open-drain bus.
    assign sda_line = sda_tb & ~sda_pull;
    assign scl_line = scl_tb & ~scl_pull;

    i2c_busy_monitor dut (
        .clk(clk), .rst_n(rst_n), .sda_i(sda_line), .scl_i(scl_line),
        .en(en), .assume_idle(assume_idle), .stop_irq_en(stop_irq_en),
        .release_cmd(release_cmd), .stop_req(stop_req),
        .bus_busy(bus_busy), .start_det(start_det), .stop_det(stop_det),
        .stop_irq(stop_irq), .engaged(engaged), .stop_pending(stop_pending),
        .sda_pull(sda_pull), .scl_pull(scl_pull)
    );

    task automatic check(input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    // Advance n rising edges, then settle on the following falling edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        step(3);
        rst_n = 1'b1;
        step(1);
        check(bus_busy, 1'b0, "reset bus_busy");
        check(start_det | stop_det | stop_irq, 1'b0, "reset pulses");
        check(sda_pull | scl_pull | stop_pending, 1'b0, "reset generator");
    endtask

    task automatic t_enable_busy;
        en = 1'b1; assume_idle = 1'b0;
        step(1);
        check(bus_busy, 1'b1, "R1 busy seeded to 1 on idle bus");
    endtask

    task automatic t_stop_irq_on;
        stop_irq_en = 1'b1;
        scl_tb = 1'b0; step(4);
        sda_tb = 1'b0; step(4);
        scl_tb = 1'b1; step(4);
        check(stop_det, 1'b0, "R5 no stop from SDA fall with SCL low");
        check(bus_busy, 1'b1, "R5 busy unchanged");
        sda_tb = 1'b1;
        step(3);
        check(stop_det, 1'b1, "R4 stop_det pulse");
        check(bus_busy, 1'b0, "R4 busy cleared");
        check(stop_irq, 1'b1, "R6 stop_irq with enable");
        step(1);
        check(stop_det, 1'b0, "R4 stop_det one cycle");
    endtask

    task automatic t_disable_then_free;
        int seen = 0;
        en = 1'b0;
        step(1);
        sda_tb = 1'b0;
        for (int i = 0; i < 6; i++) begin
            step(1);
            if (start_det || bus_busy) seen++;
        end
        check(seen != 0, 1'b0, "R9 start ignored while disabled");
        en = 1'b1; assume_idle = 1'b1;
        step(1);
        check(bus_busy, 1'b0, "R2 busy seeded 0 with SDA low");
    endtask

    task automatic t_start;
        scl_tb = 1'b0; step(4);
        sda_tb = 1'b1; step(4);
        scl_tb = 1'b1; step(4);
        sda_tb = 1'b0;
        step(2);
        check(start_det, 1'b0, "R10 not visible after two edges");
        step(1);
        check(start_det, 1'b1, "R10 R3 start_det on third edge");
        check(bus_busy, 1'b1, "R3 busy set");
        check(engaged, 1'b1, "R8 engaged on start");
        step(1);
        check(start_det, 1'b0, "R3 start_det one cycle");
    endtask

    task automatic t_data_toggles;
        int pulses = 0;
        scl_tb = 1'b0;
        for (int i = 0; i < 16; i++) begin
            if (i == 4) sda_tb = 1'b1;
            if (i == 9) sda_tb = 1'b0;
            step(1);
            if (start_det || stop_det) pulses++;
        end
        check(pulses != 0, 1'b0, "R5 no pulses from SCL-low toggles");
        check(bus_busy, 1'b1, "R5 busy held");
    endtask

    task automatic t_release;
        release_cmd = 1'b1;
        step(1);
        release_cmd = 1'b0;
        check(engaged, 1'b0, "R8 release drops engaged");
        check(bus_busy, 1'b1, "R8 busy kept after release");
    endtask

    task automatic t_stop_irq_off;
        stop_irq_en = 1'b0;
        scl_tb = 1'b1; step(4);
        sda_tb = 1'b1;
        step(3);
        check(stop_det, 1'b1, "R6 stop_det without irq enable");
        check(stop_irq, 1'b0, "R6 stop_irq suppressed");
        check(bus_busy, 1'b0, "R6 busy still cleared");
    endtask

    // Run the generator and track the drive order; returns final phase.
    task automatic run_gen(output int ph, output bit saw_stop);
        ph = 0; saw_stop = 1'b0;
        for (int i = 0; i < 300; i++) begin
            step(1);
            if (stop_det) saw_stop = 1'b1;
            case (ph)
                0: if (scl_pull && !sda_pull) ph = 1;
                1: if (scl_pull && sda_pull) ph = 2;
                2: if (!scl_pull && sda_pull) ph = 3;
                3: if (!scl_pull && !sda_pull) ph = 4;
                default: ;
            endcase
            if (ph == 4 && !stop_pending) break;
        end
    endtask

    task automatic t_generate_stop;
        int ph; bit saw;
        sda_tb = 1'b0; step(4);
        scl_tb = 1'b0; step(4);
        sda_tb = 1'b1; step(4);
        scl_tb = 1'b1; step(4);
        check(bus_busy, 1'b1, "R7 busy before generated stop");
        stop_req = 1'b1; step(1); stop_req = 1'b0;
        check(stop_pending, 1'b1, "R7 pending after request");
        run_gen(ph, saw);
        step(4);
        check(ph == 4, 1'b1, "R7 drive order");
        check(saw, 1'b1, "R7 generated stop detected");
        check(bus_busy, 1'b0, "R7 busy cleared by generated stop");
        check(stop_pending, 1'b0, "R7 pending cleared on completion");
    endtask

    task automatic t_interrupted_gen;
        int ph; bit saw;
        stop_req = 1'b1; step(1); stop_req = 1'b0;
        for (int i = 0; i < 20 && !scl_pull; i++) step(1);
        en = 1'b0;
        step(1);
        check(scl_pull | sda_pull, 1'b0, "R11 pulls released on disable");
        check(stop_pending, 1'b1, "R11 pending survives disable");
        en = 1'b1; assume_idle = 1'b0;
        run_gen(ph, saw);
        step(4);
        check(stop_pending, 1'b0, "R11 pending cleared after resumed run");
        check(bus_busy, 1'b0, "R11 resumed stop clears busy");
        en = 1'b0; step(1);
        stop_req = 1'b1; step(1); stop_req = 1'b0;
        step(3);
        check(stop_pending, 1'b0, "R11 request ignored while disabled");
    endtask

    task automatic t_disable_busy;
        en = 1'b1; assume_idle = 1'b0;
        step(1);
        check(bus_busy, 1'b1, "R1 busy seeded again");
        en = 1'b0;
        step(1);
        check(bus_busy, 1'b0, "R9 busy cleared on disable");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        t_reset();
        t_enable_busy();
        t_stop_irq_on();
        t_disable_then_free();
        t_start();
        t_data_toggles();
        t_release();
        t_stop_irq_off();
        t_generate_stop();
        t_interrupted_gen();
        t_disable_busy();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule